// File: doc/BRIEF.md
# Boot-Block Address Decoder and Lock Checker

This unit sits between a command front end and the program/erase sequencer of a 1M-word flash array. Each request carries a 20-bit word address and an operation code. The unit finds the erase block that holds the address and reports that block's index, base address and size. It also decides whether the operation may proceed and gives a reason code whenever it refuses. The block map is not uniform. Thirty-one large blocks fill the bottom of the address space. Above them sit six small parameter blocks, and the two small boot blocks are at the very top.

Protection works on two levels. Each of the 39 blocks has its own lock bit, and those bits gate data-changing operations (word write, block erase, whole-array erase). A single sticky permanent bit gates any change to the per-block lock bits. A write-protect input makes the two boot blocks behave as locked whenever it is high. A low programming-voltage flag refuses every operation except a plain read. The lock bits are held inside the unit. They change only through the three lock operations, and only when those operations are granted.

A request is sampled on a rising clock edge. Its verdict and decode appear one cycle later. The verdict is always judged against the lock state that was in force before that same edge, so a granted lock change affects only the requests that follow it.

Top module: `bblk_guard`

## Requirements
- R1: An address below 0xF8000 decodes to index addr>>15 (0 to 30), with a base aligned to 32768 words and a size of 32768.
- R2: An address at or above 0xF8000 decodes to index 31 + ((addr-0xF8000)>>12), with a base aligned to 4096 words and a size of 4096. Indices 31 to 36 are parameter blocks and indices 37 and 38 are the boot blocks.
- R3: rsp_valid equals req_valid delayed by one cycle, and the decode fields follow the address of that same sampled cycle. When rsp_valid is 0, rsp_permit is 0 and rsp_reason is 0.
- R4: The operation codes are 0 read, 1 word write, 2 block erase, 3 whole-array erase, 4 set block lock, 5 set permanent lock, 6 clear all block locks, and 7 reserved. A read is always granted with reason 0 (OK).
- R5: When vpp_low is high, every code from 1 to 6 is refused with reason 1 and changes no lock state.
- R6: A write or block erase is refused with reason 2 when the addressed block's lock is effectively set, and is granted otherwise.
- R7: While wp_on is high, blocks 37 and 38 count as locked. The stored lock bits are left unchanged, so the blocks behave normally again once wp_on falls.
- R8: A whole-array erase is refused with reason 2 if any block's lock is effectively set, including a boot block held by wp_on.
- R9: A granted set-block-lock sets the lock bit of the addressed block, and requests from the next one onward see it.
- R10: A granted set-permanent-lock makes every later set-block-lock and clear-all-locks request fail with reason 3. Only reset clears the permanent bit. Voltage refusal (reason 1) takes priority over reason 3.
- R11: A granted clear-all-locks clears all 39 block lock bits in one step.
- R12: Code 7 is refused with reason 4, and that refusal takes priority over every other reason. It changes no state.
- R13: Reset clears all block lock bits, the permanent bit and rsp_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 3 | Operation code |
| req_addr | input | 20 | Word address |
| wp_on | input | 1 | Write protect; boot blocks act as locked while high |
| vpp_low | input | 1 | Programming voltage below lockout |
| rsp_valid | output | 1 | Verdict valid |
| rsp_permit | output | 1 | Operation granted |
| rsp_reason | output | 3 | 0 ok, 1 voltage, 2 block locked, 3 permanent lock, 4 bad code |
| rsp_idx | output | 6 | Block index |
| rsp_base | output | 20 | Block base word address |
| rsp_size | output | 16 | Block size in words |

## Verification
The properties assume that req_op, req_addr, wp_on and vpp_low are stable only around the sampling edge. They also assume that the permanent bit starts clear after reset, because the checker tracks that bit from granted requests rather than reading the design. The stimulus changes inputs only on the falling edge. It draws operation codes from the whole 3-bit space, including the reserved code, and biases addresses toward the small top blocks. Set-permanent-lock is made rare, and reset is applied between random rounds, so that lock activity keeps happening instead of freezing early.

// File: rtl/bblk_pkg.sv
package bblk_pkg;

    typedef enum logic [2:0] {
        OP_READ    = 3'd0,
        OP_WRITE   = 3'd1,
        OP_ERASE   = 3'd2,
        OP_CHIP    = 3'd3,
        OP_SETLK   = 3'd4,
        OP_SETPERM = 3'd5,
        OP_CLRLK   = 3'd6,
        OP_RSVD    = 3'd7
    } op_e;

    typedef enum logic [2:0] {
        RSN_OK      = 3'd0,
        RSN_VPP     = 3'd1,
        RSN_BLKLOCK = 3'd2,
        RSN_PERM    = 3'd3,
        RSN_BADOP   = 3'd4
    } rsn_e;

endpackage

// File: rtl/bblk_map.sv
// Address to block decode: large blocks at the bottom, small blocks above.
module bblk_map #(
    parameter int ADDR_W      = 20,
    parameter int MAIN_SHIFT  = 15,
    parameter int SMALL_SHIFT = 12,
    parameter int N_MAIN      = 31,
    parameter int IDX_W       = 6,
    parameter int SIZE_W      = 16
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  idx,
    output logic [ADDR_W-1:0] base,
    output logic [SIZE_W-1:0] size
);
    localparam logic [ADDR_W-1:0] MAIN_TOP   = ADDR_W'(N_MAIN) << MAIN_SHIFT;
    localparam logic [SIZE_W-1:0] MAIN_SIZE  = SIZE_W'(1) << MAIN_SHIFT;
    localparam logic [SIZE_W-1:0] SMALL_SIZE = SIZE_W'(1) << SMALL_SHIFT;

    logic [ADDR_W-1:0] off;

    always_comb begin
        off = addr - MAIN_TOP;
        if (addr < MAIN_TOP) begin
            idx  = IDX_W'(addr >> MAIN_SHIFT);
            base = (addr >> MAIN_SHIFT) << MAIN_SHIFT;
            size = MAIN_SIZE;
        end else begin
            idx  = IDX_W'(N_MAIN) + IDX_W'(off >> SMALL_SHIFT);
            base = (addr >> SMALL_SHIFT) << SMALL_SHIFT;
            size = SMALL_SIZE;
        end
    end
endmodule

// File: rtl/bblk_lockreg.sv
// Per-block lock bits plus the sticky permanent bit.
module bblk_lockreg #(
    parameter int N_BLK = 39,
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_en,
    input  logic [IDX_W-1:0] set_idx,
    input  logic             perm_en,
    input  logic             clr_en,
    output logic [N_BLK-1:0] lock_q,
    output logic             perm_q
);
    typedef struct packed {
        logic [N_BLK-1:0] lk;
        logic             perm;
    } lk_st_t;

    lk_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_en) begin
            st_d.lk = '0;
        end
        for (int i = 0; i < N_BLK; i++) begin
            if (set_en && (set_idx == IDX_W'(i))) begin
                st_d.lk[i] = 1'b1;
            end
        end
        if (perm_en) begin
            st_d.perm = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lock_q = st_q.lk;
    assign perm_q = st_q.perm;
endmodule

// File: rtl/bblk_judge.sv
// Grant/refuse decision and lock-update strobes.
module bblk_judge
    import bblk_pkg::*;
#(
    parameter int N_BLK  = 39,
    parameter int N_BOOT = 2,
    parameter int IDX_W  = 6
) (
    input  logic             valid,
    input  logic [2:0]       op,
    input  logic             vpp_low,
    input  logic             wp_on,
    input  logic [IDX_W-1:0] idx,
    input  logic [N_BLK-1:0] lock_q,
    input  logic             perm_q,
    output logic             permit,
    output logic [2:0]       reason,
    output logic             set_en,
    output logic             perm_en,
    output logic             clr_en
);
    logic [N_BLK-1:0] boot_mask;
    logic [N_BLK-1:0] eff_lk;
    logic             blk_lk;
    logic             any_lk;
    rsn_e             rsn;

    for (genvar g = 0; g < N_BLK; g++) begin : g_boot
        assign boot_mask[g] = (g >= N_BLK - N_BOOT);
    end

    assign eff_lk = lock_q | (wp_on ? boot_mask : '0);
    assign any_lk = |eff_lk;

    always_comb begin
        blk_lk = 1'b0;
        for (int i = 0; i < N_BLK; i++) begin
            if (idx == IDX_W'(i)) begin
                blk_lk = eff_lk[i];
            end
        end
    end

    always_comb begin
        permit  = 1'b0;
        rsn     = RSN_OK;
        set_en  = 1'b0;
        perm_en = 1'b0;
        clr_en  = 1'b0;
        if (valid) begin
            case (op_e'(op))
                OP_READ: permit = 1'b1;
                OP_WRITE, OP_ERASE: begin
                    if (vpp_low)     rsn = RSN_VPP;
                    else if (blk_lk) rsn = RSN_BLKLOCK;
                    else             permit = 1'b1;
                end
                OP_CHIP: begin
                    if (vpp_low)     rsn = RSN_VPP;
                    else if (any_lk) rsn = RSN_BLKLOCK;
                    else             permit = 1'b1;
                end
                OP_SETLK: begin
                    if (vpp_low)     rsn = RSN_VPP;
                    else if (perm_q) rsn = RSN_PERM;
                    else begin
                        permit = 1'b1;
                        set_en = 1'b1;
                    end
                end
                OP_SETPERM: begin
                    if (vpp_low) rsn = RSN_VPP;
                    else begin
                        permit  = 1'b1;
                        perm_en = 1'b1;
                    end
                end
                OP_CLRLK: begin
                    if (vpp_low)     rsn = RSN_VPP;
                    else if (perm_q) rsn = RSN_PERM;
                    else begin
                        permit = 1'b1;
                        clr_en = 1'b1;
                    end
                end
                default: rsn = RSN_BADOP;
            endcase
        end
        reason = rsn;
    end
endmodule

// File: rtl/bblk_guard.sv
module bblk_guard #(
    parameter int ADDR_W      = 20,
    parameter int MAIN_SHIFT  = 15,
    parameter int SMALL_SHIFT = 12,
    parameter int N_MAIN      = 31,
    parameter int N_BOOT      = 2,
    localparam int N_SMALL    = ((1 << ADDR_W) - (N_MAIN << MAIN_SHIFT)) >> SMALL_SHIFT,
    localparam int N_BLK      = N_MAIN + N_SMALL,
    localparam int IDX_W      = $clog2(N_BLK),
    localparam int SIZE_W     = MAIN_SHIFT + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              wp_on,
    input  logic              vpp_low,
    output logic              rsp_valid,
    output logic              rsp_permit,
    output logic [2:0]        rsp_reason,
    output logic [IDX_W-1:0]  rsp_idx,
    output logic [ADDR_W-1:0] rsp_base,
    output logic [SIZE_W-1:0] rsp_size
);
    typedef struct packed {
        logic              vld;
        logic              ok;
        logic [2:0]        rsn;
        logic [IDX_W-1:0]  idx;
        logic [ADDR_W-1:0] base;
        logic [SIZE_W-1:0] size;
    } rsp_t;

    rsp_t rsp_d, rsp_q;

    logic [IDX_W-1:0]  map_idx;
    logic [ADDR_W-1:0] map_base;
    logic [SIZE_W-1:0] map_size;
    logic [N_BLK-1:0]  lock_q;
    logic              perm_q;
    logic              jd_permit;
    logic [2:0]        jd_reason;
    logic              set_en, perm_en, clr_en;

    bblk_map #(
        .ADDR_W     (ADDR_W),
        .MAIN_SHIFT (MAIN_SHIFT),
        .SMALL_SHIFT(SMALL_SHIFT),
        .N_MAIN     (N_MAIN),
        .IDX_W      (IDX_W),
        .SIZE_W     (SIZE_W)
    ) u_map (
        .addr(req_addr),
        .idx (map_idx),
        .base(map_base),
        .size(map_size)
    );

    bblk_lockreg #(
        .N_BLK(N_BLK),
        .IDX_W(IDX_W)
    ) u_lock (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_en (set_en),
        .set_idx(map_idx),
        .perm_en(perm_en),
        .clr_en (clr_en),
        .lock_q (lock_q),
        .perm_q (perm_q)
    );

    bblk_judge #(
        .N_BLK (N_BLK),
        .N_BOOT(N_BOOT),
        .IDX_W (IDX_W)
    ) u_judge (
        .valid  (req_valid),
        .op     (req_op),
        .vpp_low(vpp_low),
        .wp_on  (wp_on),
        .idx    (map_idx),
        .lock_q (lock_q),
        .perm_q (perm_q),
        .permit (jd_permit),
        .reason (jd_reason),
        .set_en (set_en),
        .perm_en(perm_en),
        .clr_en (clr_en)
    );

    always_comb begin
        rsp_d      = rsp_q;
        rsp_d.vld  = req_valid;
        rsp_d.ok   = jd_permit;
        rsp_d.rsn  = jd_reason;
        rsp_d.idx  = map_idx;
        rsp_d.base = map_base;
        rsp_d.size = map_size;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid  = rsp_q.vld;
    assign rsp_permit = rsp_q.ok;
    assign rsp_reason = rsp_q.rsn;
    assign rsp_idx    = rsp_q.idx;
    assign rsp_base   = rsp_q.base;
    assign rsp_size   = rsp_q.size;
endmodule

// File: rtl/bblk_guard_chk.sv
module bblk_guard_chk #(
    parameter int ADDR_W      = 20,
    parameter int SMALL_SHIFT = 12,
    parameter int N_MAIN      = 31,
    parameter int IDX_W       = 6,
    parameter int SIZE_W      = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [2:0]        req_op,
    input logic [ADDR_W-1:0] req_addr,
    input logic              wp_on,
    input logic              vpp_low,
    input logic              rsp_valid,
    input logic              rsp_permit,
    input logic [2:0]        rsp_reason,
    input logic [IDX_W-1:0]  rsp_idx,
    input logic [ADDR_W-1:0] rsp_base,
    input logic [SIZE_W-1:0] rsp_size
);
    logic [2:0] op_q;
    logic       vpp_q;
    logic       perm_seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q        <= 3'd0;
            vpp_q       <= 1'b0;
            perm_seen_q <= 1'b0;
        end else begin
            op_q  <= req_op;
            vpp_q <= vpp_low;
            if (req_valid && req_op == 3'd5 && !vpp_low) perm_seen_q <= 1'b1;
        end
    end

    AST_READ_GRANTED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 3'd0) |=> (rsp_permit && rsp_reason == 3'd0)); // R4

    AST_VPP_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && vpp_low && req_op != 3'd0 && req_op != 3'd7)
        |=> (rsp_valid && !rsp_permit && rsp_reason == 3'd1)); // R5

    AST_BAD_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 3'd7) |=> (!rsp_permit && rsp_reason == 3'd4)); // R12

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (!rsp_permit && rsp_reason == 3'd0)); // R3

    AST_ADDR_IN_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (($past(req_addr) >= rsp_base) &&
                       (($past(req_addr) - rsp_base) < ADDR_W'(rsp_size)))); // R1

    AST_SMALL_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_idx >= IDX_W'(N_MAIN))
        |-> (rsp_size == (SIZE_W'(1) << SMALL_SHIFT))); // R2

    AST_PERM_GATES_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && perm_seen_q && !vpp_q && (op_q == 3'd4 || op_q == 3'd6))
        |-> (!rsp_permit && rsp_reason == 3'd3)); // R10
endmodule

bind bblk_guard bblk_guard_chk #(
    .ADDR_W     (ADDR_W),
    .SMALL_SHIFT(SMALL_SHIFT),
    .N_MAIN     (N_MAIN),
    .IDX_W      (IDX_W),
    .SIZE_W     (SIZE_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_op    (req_op),
    .req_addr  (req_addr),
    .wp_on     (wp_on),
    .vpp_low   (vpp_low),
    .rsp_valid (rsp_valid),
    .rsp_permit(rsp_permit),
    .rsp_reason(rsp_reason),
    .rsp_idx   (rsp_idx),
    .rsp_base  (rsp_base),
    .rsp_size  (rsp_size)
);

// File: tb/bblk_guard_tb.sv
`timescale 1ns/1ps
module bblk_guard_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_op = 3'd0;
    logic [19:0] req_addr = 20'd0;
    logic        wp_on = 1'b0;
    logic        vpp_low = 1'b0;
    logic        rsp_valid, rsp_permit;
    logic [2:0]  rsp_reason;
    logic [5:0]  rsp_idx;
    logic [19:0] rsp_base;
    logic [15:0] rsp_size;

    int n_chk = 0;
    int n_err = 0;

    logic [38:0] ref_lk = '0;
    bit          ref_perm = 1'b0;

    always #4 clk = ~clk;

    bblk_guard u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .wp_on(wp_on), .vpp_low(vpp_low),
        .rsp_valid(rsp_valid), .rsp_permit(rsp_permit), .rsp_reason(rsp_reason),
        .rsp_idx(rsp_idx), .rsp_base(rsp_base), .rsp_size(rsp_size)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic int e_idx(logic [19:0] a);
        if (a < 20'hF8000) return int'(a >> 15);
        return 31 + int'((a - 20'hF8000) >> 12);
    endfunction

    function automatic logic [19:0] e_base(int ix);
        if (ix < 31) return 20'(ix * 32768);
        return 20'hF8000 + 20'((ix - 31) * 4096);
    endfunction

    function automatic logic [15:0] e_size(int ix);
        return (ix < 31) ? 16'd32768 : 16'd4096;
    endfunction

    // {permit, reason}
    function automatic logic [3:0] e_dec(logic [2:0] op, logic [19:0] a, bit wp, bit vl);
        logic [38:0] eff;
        eff = ref_lk | (wp ? 39'h60_0000_0000 : 39'h0);
        if (op == 3'd7) return {1'b0, 3'd4};
        if (op == 3'd0) return {1'b1, 3'd0};
        if (vl) return {1'b0, 3'd1};
        case (op)
            3'd1, 3'd2: return eff[e_idx(a)] ? {1'b0, 3'd2} : {1'b1, 3'd0};
            3'd3:       return (|eff) ? {1'b0, 3'd2} : {1'b1, 3'd0};
            3'd4, 3'd6: return ref_perm ? {1'b0, 3'd3} : {1'b1, 3'd0};
            default:    return {1'b1, 3'd0};
        endcase
    endfunction

    function automatic string dec_tag(logic [2:0] op, logic [2:0] rsn);
        if (rsn == 3'd4) return "R12";
        if (rsn == 3'd1) return "R5";
        if (rsn == 3'd3) return "R10";
        case (op)
            3'd0:       return "R4";
            3'd1, 3'd2: return "R6";
            3'd3:       return "R8";
            3'd4:       return "R9";
            3'd5:       return "R10";
            default:    return "R11";
        endcase
    endfunction

    // Called at a falling edge; returns at the falling edge after the response.
    task automatic do_req(input logic [2:0] op, input logic [19:0] a,
                          input bit wp, input bit vl, input string tag);
        logic [3:0] d;
        int         ix;
        string      t;
        d  = e_dec(op, a, wp, vl);
        ix = e_idx(a);
        t  = (tag == "") ? dec_tag(op, d[2:0]) : tag;
        req_valid = 1'b1; req_op = op; req_addr = a; wp_on = wp; vpp_low = vl;
        @(posedge clk);
        if (d[3]) begin
            if (op == 3'd4) ref_lk[ix] = 1'b1;
            if (op == 3'd5) ref_perm = 1'b1;
            if (op == 3'd6) ref_lk = '0;
        end
        @(negedge clk);
        chk("R3", "rsp_valid", 32'(rsp_valid), 32'd1);
        chk(t, "permit", 32'(rsp_permit), 32'(d[3]));
        chk(t, "reason", 32'(rsp_reason), 32'(d[2:0]));
        chk(ix < 31 ? "R1" : "R2", "idx", 32'(rsp_idx), 32'(ix));
        chk(ix < 31 ? "R1" : "R2", "base", 32'(rsp_base), 32'(e_base(ix)));
        chk(ix < 31 ? "R1" : "R2", "size", 32'(rsp_size), 32'(e_size(ix)));
    endtask

    task automatic idle_cycle();
        req_valid = 1'b0;
        req_op = 3'($urandom % 8);
        @(posedge clk);
        @(negedge clk);
        chk("R3", "idle rsp_valid", 32'(rsp_valid), 32'd0);
        chk("R3", "idle permit", 32'(rsp_permit), 32'd0);
        chk("R3", "idle reason", 32'(rsp_reason), 32'd0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; req_valid = 1'b0; wp_on = 1'b0; vpp_low = 1'b0;
        ref_lk = '0; ref_perm = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R13", "reset rsp_valid", 32'(rsp_valid), 32'd0);
        chk("R13", "reset permit", 32'(rsp_permit), 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL R3 watchdog actual 0 expected 1");
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        int seed_val;
        seed_val = $urandom(32'h5EED_0042);
        do_reset();
        // R13: nothing locked after reset
        do_req(3'd1, 20'h00000, 0, 0, "R13");
        do_req(3'd2, 20'hFFFFF, 0, 0, "R13");
        do_req(3'd5, 20'h00000, 0, 0, "R13");
        do_reset();
        // R1/R2 decode corners, R4 read always granted
        do_req(3'd0, 20'h00000, 0, 0, "R4");
        do_req(3'd0, 20'h07FFF, 0, 0, "R4");
        do_req(3'd0, 20'h08000, 0, 0, "R4");
        do_req(3'd0, 20'hF7FFF, 0, 0, "R4");
        do_req(3'd0, 20'hF8000, 0, 0, "R4");
        do_req(3'd0, 20'hFBFFF, 0, 0, "R4");
        do_req(3'd0, 20'hFE000, 0, 0, "R4");
        do_req(3'd0, 20'hFEFFF, 0, 0, "R4");
        do_req(3'd0, 20'hFF000, 0, 1, "R4");
        // R9 / R6
        do_req(3'd4, 20'h2A000, 0, 0, "R9");
        do_req(3'd1, 20'h28000, 0, 0, "R9");
        do_req(3'd2, 20'h30000, 0, 0, "R6");
        // R8 / R11
        do_req(3'd3, 20'h00000, 0, 0, "R8");
        do_req(3'd6, 20'h00000, 0, 0, "R11");
        do_req(3'd3, 20'h00000, 0, 0, "R8");
        // R7 write protect on boot blocks only
        do_req(3'd1, 20'hFF123, 1, 0, "R7");
        do_req(3'd1, 20'hFF123, 0, 0, "R7");
        do_req(3'd2, 20'hFD000, 1, 0, "R7");
        do_req(3'd3, 20'h00000, 1, 0, "R8");
        // R5 voltage refusal leaves lock state alone
        do_req(3'd4, 20'h50000, 0, 1, "R5");
        do_req(3'd1, 20'h50000, 0, 0, "R5");
        // R12 reserved code has no effect
        do_req(3'd7, 20'h12345, 0, 1, "R12");
        do_req(3'd3, 20'h00000, 0, 0, "R12");
        // R11 clears every bit at once
        do_req(3'd4, 20'h00000, 0, 0, "R9");
        do_req(3'd4, 20'hFF800, 0, 0, "R9");
        do_req(3'd4, 20'hF9000, 0, 0, "R9");
        do_req(3'd6, 20'h00000, 0, 0, "R11");
        do_req(3'd1, 20'h00000, 0, 0, "R11");
        do_req(3'd1, 20'hFF800, 0, 0, "R11");
        do_req(3'd1, 20'hF9000, 0, 0, "R11");
        // R10 permanent bit
        do_req(3'd4, 20'h50000, 0, 0, "R10");
        do_req(3'd5, 20'h00000, 0, 0, "R10");
        do_req(3'd4, 20'h58000, 0, 0, "R10");
        do_req(3'd6, 20'h00000, 0, 0, "R10");
        do_req(3'd6, 20'h00000, 0, 1, "R10");
        do_req(3'd1, 20'h50000, 0, 0, "R10");
        do_req(3'd1, 20'h58000, 0, 0, "R10");
        idle_cycle();
        // R13 reset clears permanent bit and locks
        do_reset();
        do_req(3'd1, 20'h50000, 0, 0, "R13");
        do_req(3'd4, 20'h50000, 0, 0, "R13");
        // constrained random rounds
        for (int round = 0; round < 4; round++) begin
            do_reset();
            for (int n = 0; n < 600; n++) begin
                logic [2:0]  op;
                logic [19:0] a;
                op = 3'($urandom % 8);
                if (op == 3'd5 && ($urandom % 12) != 0) op = 3'd4;
                if (op == 3'd6 && ($urandom % 3) != 0) op = 3'd1;
                if ($urandom % 2) a = 20'($urandom);
                else              a = 20'hF8000 | 20'($urandom % 32768);
                if ($urandom % 10 == 0) idle_cycle();
                do_req(op, a, ($urandom % 4) == 0, ($urandom % 8) == 0, "");
            end
        end
        req_valid = 1'b0;
        @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule